// File: doc/BRIEF.md
# Battery Presence Detection Sequencer

This block decides whether a removable battery pack is attached to a charger output node. On a start request it turns on a current sink that pulls charge off the node. It then watches a comparator that reports the node dropping below a low-voltage level. When the node drops, the sink is released and a small fixed probe charge current is switched on. A second comparator then reports whether the node has climbed above the recharge level.

The decision rests on which comes first, the timer or the threshold crossing. A real battery holds its voltage, so the discharge window (or the probe window) runs out before the comparator trips, and the block then emits a one-cycle battery-present pulse that asks for a charge cycle. A bare node with only output capacitance moves quickly. If it falls in the discharge window and then rises in the probe window, the block raises its battery-absent flag and goes back to the discharge step. It keeps looping like this until a battery shows up or an abort arrives. Both windows are set in clock cycles by parameters.

The only stream-like data here are comparator levels and single-cycle commands, so every pin is plain control or status with no handshake. The abort input stands for charge being disabled or power being lost. It returns the block to idle with all outputs off.

Top module: `batt_presence_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, sink_en, probe_en, present_pulse and absent are all 0.
- R2: In idle, start_req high (abort low) at a clock edge makes sink_en 1 from that edge on.
- R3: During discharge, node_below_low high at an edge turns sink_en off and probe_en on from that edge on, and the probe window starts again from zero.
- R4: During probe, node_above_rech high at an edge sets absent to 1, turns probe_en off and sink_en on, and starts a new discharge window.
- R5: If node_below_low stays low for DISCH_CYC edges in discharge, sink_en is high for exactly DISCH_CYC cycles. It then falls, and present_pulse is 1 for the next cycle.
- R6: If node_above_rech stays low for PROBE_CYC edges in probe, probe_en is high for exactly PROBE_CYC cycles. It then falls, and present_pulse is 1 for the next cycle.
- R7: When a threshold is crossed on the same edge at which its window runs out, the crossing wins and the window's expiry is not treated as presence.
- R8: sink_en and probe_en are never 1 in the same cycle.
- R9: present_pulse lasts one cycle, and absent is cleared on the edge that raises present_pulse.
- R10: abort high at an edge returns the block to idle. From that edge on, all four outputs are 0, no presence pulse is given, and a start request at the same edge is overridden.
- R11: start_req received while a sequence is running is ignored and does not restart the running window.
- R12: A comparator that does not matter for the current step has no effect: node_above_rech is ignored in discharge, and node_below_low is ignored in probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Begin a detection sequence (acted on in idle only) |
| abort | input | 1 | Charge disabled or power lost; return to idle |
| node_below_low | input | 1 | Comparator: node below low-voltage level |
| node_above_rech | input | 1 | Comparator: node above recharge level |
| sink_en | output | 1 | Enable the discharge current sink |
| probe_en | output | 1 | Enable the small fixed probe charge current |
| present_pulse | output | 1 | One-cycle pulse: battery found, request charging |
| absent | output | 1 | Held high while the probe loops with no battery |

## Verification
The two functions that can land on the same edge are a window running out and a comparator crossing. The bench holds the discharge window open until its final cycle and raises node_below_low there. Later it does the same with node_above_rech on the last probe cycle. In both cases it expects the next cycle to show the crossing outcome (probe, or re-discharge with absent set) and no presence pulse. The bench also combines abort with start_req on a single edge and expects idle.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISCH = 2'd1,
    ST_PROBE = 2'd2
  } bpd_state_e;
endpackage

// File: rtl/bpd_window_timer.sv
module bpd_window_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] last,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      cnt_q <= '0;
    else if (run && cnt_q != last)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == last);

  // counter never passes the window end while a window is running (R5, R6)
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last));
endmodule

// File: rtl/bpd_seq_fsm.sv
module bpd_seq_fsm
  import bpd_pkg::*;
#(
  parameter int DISCH_CYC = 1000,
  parameter int PROBE_CYC = 500,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             abort,
  input  logic             node_below_low,
  input  logic             node_above_rech,
  input  logic             expired,
  output logic             run,
  output logic             restart,
  output logic [CNT_W-1:0] last,
  output logic             sink_en,
  output logic             probe_en,
  output logic             present_pulse,
  output logic             absent
);
  localparam logic [CNT_W-1:0] DISCH_LAST = CNT_W'(DISCH_CYC - 1);
  localparam logic [CNT_W-1:0] PROBE_LAST = CNT_W'(PROBE_CYC - 1);

  bpd_state_e state_q, state_n;
  logic decide_present, mark_absent;
  logic present_q, absent_q;

  always_comb begin
    state_n        = state_q;
    decide_present = 1'b0;
    mark_absent    = 1'b0;
    if (abort) begin
      state_n = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_req) state_n = ST_DISCH;
        ST_DISCH: begin
          if (node_below_low) state_n = ST_PROBE;
          else if (expired) begin
            state_n        = ST_IDLE;
            decide_present = 1'b1;
          end
        end
        ST_PROBE: begin
          if (node_above_rech) begin
            state_n     = ST_DISCH;
            mark_absent = 1'b1;
          end else if (expired) begin
            state_n        = ST_IDLE;
            decide_present = 1'b1;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      present_q <= 1'b0;
      absent_q  <= 1'b0;
    end else begin
      state_q   <= state_n;
      present_q <= decide_present;
      if (abort || decide_present) absent_q <= 1'b0;
      else if (mark_absent)        absent_q <= 1'b1;
    end
  end

  assign run           = (state_q != ST_IDLE);
  assign restart       = (state_n != state_q);
  assign last          = (state_q == ST_PROBE) ? PROBE_LAST : DISCH_LAST;
  assign sink_en       = (state_q == ST_DISCH);
  assign probe_en      = (state_q == ST_PROBE);
  assign present_pulse = present_q;
  assign absent        = absent_q;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_req && !abort) |=> sink_en);

  p_low_to_probe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_en && node_below_low && !abort) |=> (probe_en && !sink_en));

  p_high_to_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_en && node_above_rech && !abort) |=> (absent && sink_en));

  p_crossing_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sink_en && node_below_low) || (probe_en && node_above_rech)) |=> !present_pulse);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sink_en && probe_en));

  p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    present_pulse |=> !present_pulse);

  p_present_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    present_pulse |-> !absent);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!sink_en && !probe_en && !present_pulse && !absent));
endmodule

// File: rtl/batt_presence_seq.sv
module batt_presence_seq #(
  parameter int DISCH_CYC = 1000,
  parameter int PROBE_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic abort,
  input  logic node_below_low,
  input  logic node_above_rech,
  output logic sink_en,
  output logic probe_en,
  output logic present_pulse,
  output logic absent
);
  localparam int MAX_CYC = (DISCH_CYC > PROBE_CYC) ? DISCH_CYC : PROBE_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             run, restart, expired;
  logic [CNT_W-1:0] last;

  initial begin
    if (DISCH_CYC < 1 || PROBE_CYC < 1)
      $error("window lengths must be at least one cycle");
  end

  bpd_seq_fsm #(
    .DISCH_CYC(DISCH_CYC),
    .PROBE_CYC(PROBE_CYC),
    .CNT_W    (CNT_W)
  ) fsm_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_req      (start_req),
    .abort          (abort),
    .node_below_low (node_below_low),
    .node_above_rech(node_above_rech),
    .expired        (expired),
    .run            (run),
    .restart        (restart),
    .last           (last),
    .sink_en        (sink_en),
    .probe_en       (probe_en),
    .present_pulse  (present_pulse),
    .absent         (absent)
  );

  bpd_window_timer #(
    .CNT_W(CNT_W)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .restart(restart),
    .last   (last),
    .expired(expired)
  );
endmodule

// File: tb/batt_presence_seq_tb_top.sv
module batt_presence_seq_tb_top;
  localparam int DCYC = 4;
  localparam int PCYC = 3;
  localparam int NV   = 35;

  logic clk = 1'b0;
  logic rst_n;
  logic start_req, abort, node_below_low, node_above_rech;
  logic sink_en, probe_en, present_pulse, absent;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  batt_presence_seq #(.DISCH_CYC(DCYC), .PROBE_CYC(PCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .abort(abort),
    .node_below_low(node_below_low), .node_above_rech(node_above_rech),
    .sink_en(sink_en), .probe_en(probe_en),
    .present_pulse(present_pulse), .absent(absent)
  );

  // {req, {start, abort, low, high}, {sink, probe, present, absent}}
  localparam logic [11:0] VEC [NV] = '{
    {4'd2,  4'b1000, 4'b1000},  // R2 start
    {4'd5,  4'b0000, 4'b1000},
    {4'd12, 4'b0001, 4'b1000},  // R12 high ignored in discharge
    {4'd5,  4'b0000, 4'b1000},
    {4'd5,  4'b0000, 4'b0010},  // R5 discharge window ran out
    {4'd9,  4'b0000, 4'b0000},  // R9 pulse is one cycle
    {4'd2,  4'b1000, 4'b1000},
    {4'd3,  4'b0010, 4'b0100},  // R3 low crossing
    {4'd3,  4'b0000, 4'b0100},
    {4'd4,  4'b0001, 4'b1001},  // R4 high crossing -> absent
    {4'd4,  4'b0000, 4'b1001},
    {4'd3,  4'b0010, 4'b0101},
    {4'd12, 4'b0010, 4'b0101},  // R12 low ignored in probe
    {4'd6,  4'b0000, 4'b0101},
    {4'd6,  4'b0000, 4'b0010},  // R6 probe window ran out, R9 absent cleared
    {4'd9,  4'b0000, 4'b0000},
    {4'd2,  4'b1000, 4'b1000},
    {4'd5,  4'b0000, 4'b1000},
    {4'd5,  4'b0000, 4'b1000},
    {4'd5,  4'b0000, 4'b1000},
    {4'd7,  4'b0010, 4'b0100},  // R7 low on last discharge cycle
    {4'd6,  4'b0000, 4'b0100},
    {4'd6,  4'b0000, 4'b0100},
    {4'd7,  4'b0001, 4'b1001},  // R7 high on last probe cycle
    {4'd10, 4'b1100, 4'b0000},  // R10 abort beats start
    {4'd10, 4'b0000, 4'b0000},
    {4'd2,  4'b1000, 4'b1000},
    {4'd11, 4'b1001, 4'b1000},  // R11 start ignored while running
    {4'd11, 4'b0000, 4'b1000},
    {4'd11, 4'b0000, 4'b1000},
    {4'd11, 4'b0000, 4'b0010},
    {4'd2,  4'b1000, 4'b1000},
    {4'd3,  4'b0010, 4'b0100},
    {4'd10, 4'b0100, 4'b0000},  // R10 abort in probe
    {4'd10, 4'b0000, 4'b0000}
  };

  task automatic check_out(input int req, input logic [3:0] exp);
    logic [3:0] act;
    act = {sink_en, probe_en, present_pulse, absent};
    checks++;
    if (sink_en && probe_en) begin
      errors++;
      $display("FAIL R8 both enables high act=%b exp=%b", act, exp);
    end
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d outputs {sink,probe,present,absent} act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {start_req, abort, node_below_low, node_above_rech} = v;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(4'b0000);
    repeat (3) @(negedge clk);
    check_out(1, 4'b0000);              // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_out(1, 4'b0000);              // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][7:4]);
      @(negedge clk);
      check_out(int'(VEC[i][11:8]), VEC[i][3:0]);
    end

    // R1 reset in the middle of a discharge
    drive(4'b1000);
    @(negedge clk);
    drive(4'b0000);
    check_out(2, 4'b1000);
    rst_n = 1'b0;
    @(negedge clk);
    check_out(1, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_out(1, 4'b0000);

    // R4 repeated looping keeps absent high across two probe rounds
    drive(4'b1000); @(negedge clk);
    drive(4'b0010); @(negedge clk);
    drive(4'b0001); @(negedge clk);
    check_out(4, 4'b1001);
    drive(4'b0010); @(negedge clk);
    drive(4'b0001); @(negedge clk);
    check_out(4, 4'b1001);
    drive(4'b0100); @(negedge clk);
    check_out(10, 4'b0000);
    drive(4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule